// File: doc/BRIEF.md
# Multi-mode integer register divider

This block is the division engine of a CPU execution unit. The dividend comes from the destination register and the divisor from the source register. One result word is produced and written back over the destination. Three mode bits pick the variant. `op_signed` selects two's-complement or unsigned operands. `op_ext` selects the extended form, which packs a remainder next to the quotient, or the plain form, which returns the quotient only. `op_wide` selects the larger of the two operand sizes.

The four width combinations are fixed by `op_ext` and `op_wide`:

| Form | Dividend | Divisor | Result |
|---|---|---|---|
| extended narrow | 16 bits | 8 bits | 8-bit quotient and 8-bit remainder |
| extended wide | 32 bits | 16 bits | 16-bit quotient and 16-bit remainder |
| plain narrow | 16 bits | 16 bits | 16-bit quotient |
| plain wide | 32 bits | 32 bits | 32-bit quotient |

The datapath uses restoring shift-subtract on operand magnitudes and produces one quotient bit per clock. It then spends one cycle restoring the signs and packing the result. A start pulse is accepted while the block is idle. `busy` stays high while the operation runs, and `done` pulses once with the result and with quotient-negative, quotient-zero and divide-by-zero flags for the condition-code logic.

Top module: `regdiv_unit`

## Requirements
- R1: While reset is held and immediately after it, `busy`, `done`, `result`, `flag_neg`, `flag_zero` and `flag_dz` are all 0.
- R2: Extended forms (`op_ext`=1):
  - With `op_wide`=0, the low 16 bits of `dst_val` are divided by the low 8 bits of `src_val`. The result is `dst_val[31:16]` unchanged, then the remainder in bits 15:8, then the quotient in bits 7:0.
  - With `op_wide`=1, all 32 bits of `dst_val` are divided by `src_val[15:0]`. The remainder goes in bits 31:16 and the quotient in bits 15:0.
  - When the quotient does not fit its field, the result is not defined.
- R3: Plain forms (`op_ext`=0):
  - With `op_wide`=0, `dst_val[15:0]` is divided by `src_val[15:0]`. The result is `dst_val[31:16]` unchanged, then the 16-bit quotient.
  - With `op_wide`=1, the full 32-bit quotient of `dst_val` by `src_val` is returned.
- R4: With `op_signed`=1, operands are read as two's complement at their form's widths. The quotient truncates toward zero and is negative when the operand signs differ. The remainder carries the sign of the dividend.
- R5: A start accepted at a clock edge makes `done` pulse for one cycle. The pulse comes exactly Q+1 edges later, where Q is the quotient width (8, 16, 16 or 32 for the four forms). `busy` is high from the accept edge up to the done edge and is low while `done` is high.
- R6: `start` is ignored while `busy` is high. The result of the running operation is not affected.
- R7: A divisor that is zero at its form's width ends the operation at the first edge after acceptance. It then returns the original `dst_val` as `result`, with `flag_dz`=1 and `flag_neg`=`flag_zero`=0.
- R8: After a nonzero divisor, `flag_neg` equals the top bit of the quotient at its width, and `flag_zero` is 1 exactly when the quotient is zero. `flag_dz` is 0.
- R9: `result` and the flags keep their values from one `done` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division (honoured when idle) |
| op_signed | input | 1 | 1 = two's-complement operands |
| op_ext | input | 1 | 1 = extended form with remainder |
| op_wide | input | 1 | 1 = larger operand size |
| dst_val | input | 32 | Destination register value (dividend) |
| src_val | input | 32 | Source register value (divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Value to write back to the destination |
| flag_neg | output | 1 | Quotient negative |
| flag_zero | output | 1 | Quotient zero |
| flag_dz | output | 1 | Divisor was zero |

## Verification
Each of the four forms is run both unsigned and signed.
- The unsigned vectors pin down the field packing and which upper destination bits survive.
- The signed cases mix operand signs, so that quotient negation and remainder sign are checked separately, including a zero quotient with a negative remainder.
- Zero divisors are tried with nonzero bits lying outside the divisor's width, which shows that only the form's width is tested.
- The cycle count to `done` is measured for every form, a start issued mid-operation must leave the running result intact, and the outputs are watched for holding after completion.

// File: rtl/regdiv_pkg.sv
package regdiv_pkg;

    localparam int unsigned REGDIV_XLEN = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic sgn;
        logic ext;
        logic wide;
    } div_form_t;

endpackage

// File: rtl/regdiv_prep.sv
module regdiv_prep
    import regdiv_pkg::*;
#(
    parameter int unsigned XLEN = REGDIV_XLEN
) (
    input  div_form_t                      form,
    input  logic [XLEN-1:0]                dvd_raw,
    input  logic [XLEN-1:0]                dvs_raw,
    output logic [XLEN-1:0]                p_init,
    output logic [XLEN-1:0]                q_init,
    output logic [XLEN-1:0]                d_mag,
    output logic [$clog2(XLEN):0]          qwidth,
    output logic                           neg_q,
    output logic                           neg_r,
    output logic                           dvs_zero
);
    localparam int unsigned HW = XLEN / 2;
    localparam int unsigned QW = XLEN / 4;
    localparam int unsigned CW = $clog2(XLEN) + 1;

    logic [XLEN-1:0] dvd_ext;
    logic [XLEN-1:0] dvs_ext;
    logic [XLEN-1:0] dvd_mag;
    logic            s_dvd;
    logic            s_dvs;
    logic [CW-1:0]   lsh;

    always_comb begin
        // Dividend width: half word for narrow forms, full word for wide ones.
        if (form.wide) begin
            dvd_ext = dvd_raw;
        end else begin
            dvd_ext = {{(XLEN-HW){form.sgn & dvd_raw[HW-1]}}, dvd_raw[HW-1:0]};
        end

        // Divisor width and quotient width coincide for every form.
        unique case ({form.ext, form.wide})
            2'b10: begin
                dvs_ext = {{(XLEN-QW){form.sgn & dvs_raw[QW-1]}}, dvs_raw[QW-1:0]};
                qwidth  = CW'(QW);
            end
            2'b11, 2'b00: begin
                dvs_ext = {{(XLEN-HW){form.sgn & dvs_raw[HW-1]}}, dvs_raw[HW-1:0]};
                qwidth  = CW'(HW);
            end
            default: begin
                dvs_ext = dvs_raw;
                qwidth  = CW'(XLEN);
            end
        endcase

        s_dvd    = form.sgn & dvd_ext[XLEN-1];
        s_dvs    = form.sgn & dvs_ext[XLEN-1];
        dvd_mag  = s_dvd ? (~dvd_ext + 1'b1) : dvd_ext;
        d_mag    = s_dvs ? (~dvs_ext + 1'b1) : dvs_ext;
        dvs_zero = (dvs_ext == '0);
        neg_q    = s_dvd ^ s_dvs;
        neg_r    = s_dvd;

        // Quotient-width dividend bits are left-aligned in the shift register;
        // extended forms preload the upper half as the partial remainder.
        lsh    = CW'(XLEN) - qwidth;
        q_init = dvd_mag << lsh;
        p_init = form.ext ? (dvd_mag >> qwidth) : '0;
    end

endmodule

// File: rtl/regdiv_step.sv
module regdiv_step #(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] p_cur,
    input  logic [XLEN-1:0] q_cur,
    input  logic [XLEN-1:0] d_mag,
    output logic [XLEN-1:0] p_nxt,
    output logic [XLEN-1:0] q_nxt
);
    logic [XLEN:0] trial;
    logic [XLEN:0] diff;
    logic          fits;

    always_comb begin
        trial = {p_cur, q_cur[XLEN-1]};
        diff  = trial - {1'b0, d_mag};
        fits  = ~diff[XLEN];
        p_nxt = fits ? diff[XLEN-1:0] : trial[XLEN-1:0];
        q_nxt = {q_cur[XLEN-2:0], fits};
    end

endmodule

// File: rtl/regdiv_pack.sv
module regdiv_pack
    import regdiv_pkg::*;
#(
    parameter int unsigned XLEN = REGDIV_XLEN
) (
    input  div_form_t       form,
    input  logic [XLEN-1:0] q_raw,
    input  logic [XLEN-1:0] r_raw,
    input  logic            neg_q,
    input  logic            neg_r,
    input  logic [XLEN-1:0] dst_keep,
    output logic [XLEN-1:0] packed_res,
    output logic            q_negative,
    output logic            q_is_zero
);
    localparam int unsigned HW = XLEN / 2;
    localparam int unsigned QW = XLEN / 4;
    localparam logic [XLEN-1:0] M_QW = {{(XLEN-QW){1'b0}}, {QW{1'b1}}};
    localparam logic [XLEN-1:0] M_HW = {{(XLEN-HW){1'b0}}, {HW{1'b1}}};

    logic [XLEN-1:0] mask;
    logic [XLEN-1:0] q_fix;
    logic [XLEN-1:0] r_fix;

    always_comb begin
        unique case ({form.ext, form.wide})
            2'b10:        mask = M_QW;
            2'b11, 2'b00: mask = M_HW;
            default:      mask = '1;
        endcase

        q_fix = (neg_q ? (~q_raw + 1'b1) : q_raw) & mask;
        r_fix = (neg_r ? (~r_raw + 1'b1) : r_raw) & mask;
        q_is_zero = (q_fix == '0);

        unique case ({form.ext, form.wide})
            2'b10: begin
                packed_res = {dst_keep[XLEN-1:HW], r_fix[QW-1:0], q_fix[QW-1:0]};
                q_negative = q_fix[QW-1];
            end
            2'b11: begin
                packed_res = {r_fix[HW-1:0], q_fix[HW-1:0]};
                q_negative = q_fix[HW-1];
            end
            2'b00: begin
                packed_res = {dst_keep[XLEN-1:HW], q_fix[HW-1:0]};
                q_negative = q_fix[HW-1];
            end
            default: begin
                packed_res = q_fix;
                q_negative = q_fix[XLEN-1];
            end
        endcase
    end

endmodule

// File: rtl/regdiv_unit.sv
module regdiv_unit
    import regdiv_pkg::*;
#(
    parameter int unsigned XLEN = REGDIV_XLEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_signed,
    input  logic            op_ext,
    input  logic            op_wide,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic            flag_neg,
    output logic            flag_zero,
    output logic            flag_dz
);
    localparam int unsigned CW = $clog2(XLEN) + 1;

    typedef struct packed {
        div_state_e      st;
        logic [CW-1:0]   cnt;
        logic [XLEN-1:0] p;
        logic [XLEN-1:0] q;
        logic [XLEN-1:0] d;
        logic [XLEN-1:0] dst;
        div_form_t       form;
        logic            neg_q;
        logic            neg_r;
        logic            dz;
        logic            done;
        logic [XLEN-1:0] res;
        logic            fn;
        logic            fz;
        logic            fdz;
    } regs_t;

    regs_t r_d, r_q;

    div_form_t       in_form;
    logic [XLEN-1:0] pre_p, pre_q, pre_d;
    logic [CW-1:0]   pre_qw;
    logic            pre_nq, pre_nr, pre_zero;
    logic [XLEN-1:0] stp_p, stp_q;
    logic [XLEN-1:0] pk_res;
    logic            pk_n, pk_z;

    assign in_form = '{sgn: op_signed, ext: op_ext, wide: op_wide};

    regdiv_prep #(.XLEN(XLEN)) u_prep (
        .form     (in_form),
        .dvd_raw  (dst_val),
        .dvs_raw  (src_val),
        .p_init   (pre_p),
        .q_init   (pre_q),
        .d_mag    (pre_d),
        .qwidth   (pre_qw),
        .neg_q    (pre_nq),
        .neg_r    (pre_nr),
        .dvs_zero (pre_zero)
    );

    regdiv_step #(.XLEN(XLEN)) u_step (
        .p_cur (r_q.p),
        .q_cur (r_q.q),
        .d_mag (r_q.d),
        .p_nxt (stp_p),
        .q_nxt (stp_q)
    );

    regdiv_pack #(.XLEN(XLEN)) u_pack (
        .form       (r_q.form),
        .q_raw      (r_q.q),
        .r_raw      (r_q.p),
        .neg_q      (r_q.neg_q),
        .neg_r      (r_q.neg_r),
        .dst_keep   (r_q.dst),
        .packed_res (pk_res),
        .q_negative (pk_n),
        .q_is_zero  (pk_z)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.p     = pre_p;
                    r_d.q     = pre_q;
                    r_d.d     = pre_d;
                    r_d.cnt   = pre_qw;
                    r_d.dst   = dst_val;
                    r_d.form  = in_form;
                    r_d.neg_q = pre_nq;
                    r_d.neg_r = pre_nr;
                    r_d.dz    = pre_zero;
                    r_d.st    = pre_zero ? ST_FIX : ST_ITER;
                end
            end
            ST_ITER: begin
                r_d.p   = stp_p;
                r_d.q   = stp_q;
                r_d.cnt = r_q.cnt - 1'b1;
                if (r_q.cnt == CW'(1)) begin
                    r_d.st = ST_FIX;
                end
            end
            ST_FIX: begin
                r_d.done = 1'b1;
                r_d.st   = ST_IDLE;
                if (r_q.dz) begin
                    r_d.res = r_q.dst;
                    r_d.fn  = 1'b0;
                    r_d.fz  = 1'b0;
                    r_d.fdz = 1'b1;
                end else begin
                    r_d.res = pk_res;
                    r_d.fn  = pk_n;
                    r_d.fz  = pk_z;
                    r_d.fdz = 1'b0;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = r_q.done;
    assign result    = r_q.res;
    assign flag_neg  = r_q.fn;
    assign flag_zero = r_q.fz;
    assign flag_dz   = r_q.fdz;

endmodule

// File: rtl/regdiv_unit_chk.sv
module regdiv_unit_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result,
    input logic            flag_neg,
    input logic            flag_zero,
    input logic            flag_dz
);
    localparam int unsigned LW = $clog2(XLEN + 2) + 1;

    logic [LW-1:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (busy) begin
            run_len <= run_len + 1'b1;
        end else begin
            run_len <= '0;
        end
    end

    // R5: completion is a single-cycle pulse
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: no overlap of busy and done
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5: an accepted start makes the unit busy
    p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5: done only after at least one and at most XLEN+1 busy cycles
    p_latency_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len >= LW'(1) && run_len <= LW'(XLEN + 1)));

    // R7: divide-by-zero reports neither negative nor zero quotient
    p_dz_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_dz |-> (!flag_neg && !flag_zero));

    // R9: outputs only move with a done pulse
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(flag_neg) && $stable(flag_zero) && $stable(flag_dz)));

endmodule

bind regdiv_unit regdiv_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .result    (result),
    .flag_neg  (flag_neg),
    .flag_zero (flag_zero),
    .flag_dz   (flag_dz)
);

// File: tb/regdiv_unit_bench.sv
`timescale 1ns/1ps
module regdiv_unit_bench;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic        op_signed, op_ext, op_wide;
    logic [31:0] dst_val, src_val;
    logic        busy, done;
    logic [31:0] result;
    logic        flag_neg, flag_zero, flag_dz;

    int total = 0;
    int bad   = 0;

    regdiv_unit u_regdiv_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_signed (op_signed),
        .op_ext    (op_ext),
        .op_wide   (op_wide),
        .dst_val   (dst_val),
        .src_val   (src_val),
        .busy      (busy),
        .done      (done),
        .result    (result),
        .flag_neg  (flag_neg),
        .flag_zero (flag_zero),
        .flag_dz   (flag_dz)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    typedef struct packed {
        logic        sgn;
        logic        ext;
        logic        wide;
        logic [31:0] dst;
        logic [31:0] src;
        logic [31:0] res;
        logic        n;
        logic        z;
        logic        dz;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b0, 32'hAAAA_03E8, 32'h0000_0007, 32'hAAAA_068E, 1'b1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 32'h0001_0000, 32'h0000_0003, 32'h0001_5555, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 32'h1234_FFFF, 32'hFFFF_0010, 32'h1234_0FFF, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0001_0000, 32'h0000_FFFF, 1'b0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b0, 32'h0000_FF9C, 32'h0000_0007, 32'h0000_FEF2, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 32'h0000_03E8, 32'h0000_FFF9, 32'h0006_FF72, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b0, 32'h5A5A_8000, 32'h0000_0002, 32'h5A5A_C000, 1'b1, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 32'h0000_0003, 1'b0, 1'b0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 32'h0000_0005, 32'h0000_0009, 32'h0000_0000, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b1, 1'b0, 32'h0000_FFFB, 32'h0000_0007, 32'h0000_FB00, 1'b0, 1'b1, 1'b0},
        '{1'b1, 1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0000_0000, 32'hDEAD_BEEF, 1'b0, 1'b0, 1'b1},
        '{1'b0, 1'b1, 1'b0, 32'h1234_5678, 32'h0000_0100, 32'h1234_5678, 1'b0, 1'b0, 1'b1},
        '{1'b1, 1'b0, 1'b1, 32'h8000_0000, 32'h0000_0001, 32'h8000_0000, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int qwidth_of(input logic ext, input logic wide);
        if (ext) return wide ? 16 : 8;
        return wide ? 32 : 16;
    endfunction

    function automatic string func_tag(input vec_t v);
        if (v.dz)  return "R7";
        if (v.sgn) return "R4";
        if (v.ext) return "R2";
        return "R3";
    endfunction

    // Drive an operation; returns the number of edges from accept to done.
    task automatic run_op(input logic sg, input logic ex, input logic wd,
                          input logic [31:0] dv, input logic [31:0] sv,
                          output int edges);
        @(negedge clk);
        op_signed = sg; op_ext = ex; op_wide = wd;
        dst_val = dv; src_val = sv; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        edges = 0;
        for (int k = 0; k < 100; k++) begin
            if (done) break;
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int ed;
        logic [31:0] held;
        rst_n = 1'b0; start = 1'b0;
        op_signed = 1'b0; op_ext = 1'b0; op_wide = 1'b0;
        dst_val = '0; src_val = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        check("R1", "busy/done", {30'd0, busy, done}, 32'd0);
        check("R1", "result", result, 32'd0);
        check("R1", "flags", {29'd0, flag_neg, flag_zero, flag_dz}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "after release", {27'd0, busy, done, flag_neg, flag_zero, flag_dz}, 32'd0);

        // Table walk: function, flags and latency per form
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            run_op(v.sgn, v.ext, v.wide, v.dst, v.src, ed);
            check(func_tag(v), $sformatf("vector %0d result", i), result, v.res);
            check(v.dz ? "R7" : "R8", $sformatf("vector %0d flags", i),
                  {29'd0, flag_neg, flag_zero, flag_dz}, {29'd0, v.n, v.z, v.dz});
            check(v.dz ? "R7" : "R5", $sformatf("vector %0d latency", i),
                  ed, v.dz ? 32'd1 : 32'(qwidth_of(v.ext, v.wide) + 1));
            check("R5", $sformatf("vector %0d busy at done", i), {31'd0, busy}, 32'd0);
        end

        // R5: busy throughout an operation, done pulse lasts one cycle
        @(negedge clk);
        op_signed = 0; op_ext = 1; op_wide = 0; dst_val = 32'h0000_0064; src_val = 32'h0000_000A;
        start = 1;
        @(posedge clk); @(negedge clk); start = 0;
        check("R5", "busy after accept", {31'd0, busy}, 32'd1);
        repeat (8) @(negedge clk);
        check("R5", "busy before last edge", {31'd0, busy}, 32'd1);
        @(negedge clk);
        check("R5", "done after Q+1 edges", {30'd0, busy, done}, 32'd1);
        check("R2", "100/10 byte form", result, 32'h0000_000A);
        @(negedge clk);
        check("R5", "done one cycle", {31'd0, done}, 32'd0);

        // R6: start while busy is ignored
        @(negedge clk);
        op_signed = 0; op_ext = 0; op_wide = 1; dst_val = 32'd100; src_val = 32'd10;
        start = 1;
        @(posedge clk); @(negedge clk); start = 0;
        repeat (5) @(negedge clk);
        op_signed = 1; op_ext = 1; op_wide = 0; dst_val = 32'h0000_0077; src_val = 32'h1;
        start = 1;
        @(negedge clk);
        start = 0;
        ed = 0;
        for (int k = 0; k < 100; k++) begin
            if (done) break;
            @(negedge clk);
            ed++;
        end
        check("R6", "running result kept", result, 32'h0000_000A);
        check("R6", "latency unchanged", ed, 32'd27);
        @(negedge clk);
        check("R6", "no second operation", {30'd0, busy, done}, 32'd0);

        // R9: outputs hold with inputs changing and no start
        held = result;
        dst_val = 32'hFFFF_FFFF; src_val = 32'h0; op_signed = 1;
        repeat (4) @(negedge clk);
        check("R9", "result held", result, held);
        check("R9", "flags held", {29'd0, flag_neg, flag_zero, flag_dz}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule